// File: doc/BRIEF.md
# DMX512 Relay Receiver

This block listens to a DMX512 lighting-control stream that has already been turned into a single-ended logic signal. The line idles high. The block finds the break that opens each frame and checks that the start code is 0x00. It then picks out eight consecutive channel values, starting at a channel number that software selects. Each of those eight values is compared against a threshold and drives one relay output. A value above 127 closes its relay.

The receiver is built to cope with a known weakness of ordinary serial receivers. A long low level must be reported once, as a single break, and not as a run of bogus zero bytes. After a missing stop bit, the receiver does not look for a new start bit until the line has been high for a full bit time. A start bit that follows a short mark-after-break is therefore caught correctly, with no bogus byte before it.

Relays change only when every mapped slot of a frame with a good start code has arrived. A one-cycle strobe marks that moment. A stale flag reports that no good frame has arrived within the refresh window; while it is set, the relays keep their last state.

Top module: `dmx_relay_rx`

## Requirements
- R1: Each slot is one low start bit, eight data bits sent LSB first, and two high stop bits, each bit lasting 16 sample ticks. The value of a bit is the majority of its three middle samples, so a single wrong sample inside a bit does not change the received value.
- R2: A low level that starts at a start bit and has all-zero data and a low stop-bit sample is one break, however long it lasts. It restarts slot counting at slot 0. It does not change `ferr_count`.
- R3: A start code that follows a mark-after-break of only two bit times is received correctly.
- R4: After a missing stop bit, no start bit is accepted until the line has stayed high for 16 consecutive samples (one bit time). A high pulse shorter than that, inside or after a break, does not re-arm the receiver.
- R5: A frame whose slot 0 is not 0x00 leaves the relays unchanged and produces no strobe. It sets `start_code_err`, which stays high until the next break.
- R6: `relay[i]` takes the value (slot[`base_chan`+i] > 127) for i = 0..7. `base_chan` is a slot number from 1 to 505; 0 maps nothing.
- R7: The relays update only after slot `base_chan`+7 of a frame with a good start code has been received. A frame that ends earlier changes nothing.
- R8: `frame_valid` is high for exactly one clock cycle for each accepted frame, in the same cycle the new relay values appear.
- R9: A missing stop bit on a byte with nonzero data increments `ferr_count`, which saturates at its maximum value. The frame in progress is dropped, so its later slots are ignored.
- R10: `stale` is high from reset until the first accepted frame. It rises again when no frame has been accepted for `STALE_CLKS` cycles, and it clears on the next accepted frame. While it is high, the relays hold their state.
- R11: After reset, `relay` is 0, `frame_valid` and `start_code_err` are 0, `ferr_count` is 0 and `stale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial DMX line, idle high, asynchronous |
| base_chan | input | 10 | First slot mapped to relay 0 |
| relay | output | 8 | Relay states, 1 = closed |
| frame_valid | output | 1 | One-cycle strobe on each accepted frame |
| start_code_err | output | 1 | Last frame had a nonzero start code |
| stale | output | 1 | No accepted frame within the refresh window |
| ferr_count | output | 8 | Saturating count of framing errors |

## Verification
The hardest case to reach from the ports is the re-arm rule. The receiver must refuse a start bit after a break until a full bit of mark has been seen. A well-formed stream never tests this, because its mark-after-break is already long enough. The stimulus therefore ends a break with a half-bit high pulse, drops the line low again for three bits, and only then gives a two-bit mark before a valid frame. A receiver that re-armed on that pulse would decode a nonzero start code and drop the frame. Single-sample glitches placed at the centre of data bits, and bytes with a deliberately low stop bit, drive the majority vote and the framing-error path.

// File: rtl/dmx_rx_pkg.sv
// Shared types for the DMX relay receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package dmx_rx_pkg;

    // Byte receiver states
    typedef enum logic [1:0] {
        RX_WAIT_MARK = 2'd0,   // waiting for one full bit of mark before re-arming
        RX_HUNT      = 2'd1,   // armed, looking for a falling edge
        RX_RECV      = 2'd2    // shifting a slot in
    } rx_state_e;

    // Event produced by the byte receiver, one cycle wide
    typedef struct packed {
        logic       byte_stb;  // good byte with valid stop bit
        logic       brk_stb;   // break (all-zero byte, missing stop)
        logic       ferr_stb;  // framing error (nonzero byte, missing stop)
        logic [7:0] data;      // received byte
    } rx_evt_t;

endpackage

// File: rtl/dmx_line_sampler.sv
// Line sampler: brings the asynchronous serial line into the clock domain
// and produces one sample strobe per oversampling tick.
// Assumes: CLKS_PER_TICK clocks make one tick (1/16 of a bit).
module dmx_line_sampler #(
    parameter int CLKS_PER_TICK = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic smp_en,
    output logic smp
);
    localparam int TICK_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

    logic [1:0]        sync_q;
    logic [TICK_W-1:0] tick_cnt;

    // Two-stage synchroniser; resets to mark (idle high)
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    // Tick divider and sample register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            smp_en   <= 1'b0;
            smp      <= 1'b1;
        end else if (tick_cnt == TICK_W'(CLKS_PER_TICK - 1)) begin
            tick_cnt <= '0;
            smp_en   <= 1'b1;
            smp      <= sync_q[1];
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
            smp_en   <= 1'b0;
        end
    end

endmodule

// File: rtl/dmx_byte_rx.sv
// Byte receiver: turns the sample stream into byte, break and framing-error
// events. It re-arms the start-bit search only after a valid stop bit, or
// after OVS consecutive high samples following a missing stop bit.
// Assumes: OVS is a power of two, at least 4.
module dmx_byte_rx
    import dmx_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    smp_en,
    input  logic    smp,
    output rx_evt_t evt
);
    localparam int PH_W     = $clog2(OVS);
    localparam int MC_W     = $clog2(OVS + 1);
    localparam int MID      = OVS / 2 + 1;   // last of the three middle samples
    localparam int STOP_IDX = 9;             // bit index of the first stop bit

    rx_state_e     state;
    logic [PH_W-1:0] ph;
    logic [3:0]    bit_idx;
    logic [1:0]    win;                      // two previous samples
    logic [MC_W-1:0] mark_cnt;
    logic [7:0]    shreg;
    logic          maj;

    // Majority of the two previous samples and the current one
    always_comb maj = (win[1] & win[0]) | (win[1] & smp) | (win[0] & smp);

    // Receive state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_WAIT_MARK;
            ph       <= '0;
            bit_idx  <= '0;
            win      <= 2'b11;
            mark_cnt <= '0;
            shreg    <= '0;
            evt      <= '0;
        end else begin
            evt.byte_stb <= 1'b0;
            evt.brk_stb  <= 1'b0;
            evt.ferr_stb <= 1'b0;
            if (smp_en) begin
                win <= {win[0], smp};
                case (state)
                    RX_WAIT_MARK: begin
                        if (!smp)                                 mark_cnt <= '0;
                        else if (mark_cnt == MC_W'(OVS - 1)) begin
                            state    <= RX_HUNT;
                            mark_cnt <= '0;
                        end else                                  mark_cnt <= mark_cnt + 1'b1;
                    end
                    RX_HUNT: begin
                        if (!smp) begin
                            state   <= RX_RECV;
                            ph      <= PH_W'(1);
                            bit_idx <= '0;
                        end
                    end
                    RX_RECV: begin
                        ph <= ph + 1'b1;
                        if (ph == PH_W'(MID)) begin
                            if (bit_idx == 4'd0) begin
                                if (maj) state <= RX_HUNT;   // false start
                                else     bit_idx <= 4'd1;
                            end else if (bit_idx != 4'(STOP_IDX)) begin
                                shreg   <= {maj, shreg[7:1]};
                                bit_idx <= bit_idx + 1'b1;
                            end else if (maj) begin
                                evt.byte_stb <= 1'b1;
                                evt.data     <= shreg;
                                state        <= RX_HUNT;
                            end else begin
                                evt.brk_stb  <= (shreg == 8'h00);
                                evt.ferr_stb <= (shreg != 8'h00);
                                evt.data     <= shreg;
                                state        <= RX_WAIT_MARK;
                                mark_cnt     <= '0;
                            end
                        end
                    end
                    default: state <= RX_WAIT_MARK;
                endcase
            end
        end
    end

    // R2: at most one kind of event per cycle
    p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.byte_stb, evt.brk_stb, evt.ferr_stb}));

    // R4: a low sample while waiting for mark keeps the receiver disarmed
    p_low_keeps_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT_MARK && smp_en && !smp) |=> (state == RX_WAIT_MARK));

    // R1: bit index never passes the first stop bit
    p_bit_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV) |-> (bit_idx <= 4'(STOP_IDX)));

endmodule

// File: rtl/dmx_frame_ctl.sv
// Frame controller: counts slots from each break, checks the start code,
// stages the mapped slots and commits them to the relays once the last
// mapped slot arrives. Also keeps the framing-error count and stale timer.
// Assumes: one event at most per cycle from the byte receiver.
module dmx_frame_ctl
    import dmx_rx_pkg::*;
#(
    parameter int N_RELAY    = 8,
    parameter int MAX_SLOTS  = 512,
    parameter int THRESH     = 127,
    parameter int CNT_W      = 8,
    parameter int STALE_CLKS = 125_000_000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  rx_evt_t                            evt,
    input  logic [$clog2(MAX_SLOTS+2)-1:0]     base_chan,
    output logic [N_RELAY-1:0]                 relay,
    output logic                               frame_valid,
    output logic                               start_code_err,
    output logic                               stale,
    output logic [CNT_W-1:0]                   ferr_count
);
    localparam int SLOT_W = $clog2(MAX_SLOTS + 2);
    localparam int IDX_W  = (N_RELAY > 1) ? $clog2(N_RELAY) : 1;
    localparam int STL_W  = $clog2(STALE_CLKS + 1);

    logic              in_frame;
    logic [SLOT_W-1:0] slot_idx;
    logic [N_RELAY-1:0] staged, stg_nx;
    logic [SLOT_W:0]   rel;
    logic              hit, last, commit;
    logic [STL_W-1:0]  stl_cnt;
    logic [N_RELAY-1:0] above;

    // Position of the current slot relative to the base channel
    always_comb begin
        rel  = {1'b0, slot_idx} - {1'b0, base_chan};
        hit  = (base_chan != '0) && (slot_idx >= base_chan) && (rel < (SLOT_W+1)'(N_RELAY));
        last = hit && (rel == (SLOT_W+1)'(N_RELAY - 1));
    end

    // Threshold compare, one per relay lane
    for (genvar g = 0; g < N_RELAY; g++) begin : g_lane
        assign above[g] = (int'(evt.data) > THRESH);
    end

    // Next staged relay pattern and commit decision
    always_comb begin
        stg_nx = staged;
        commit = 1'b0;
        if (evt.byte_stb && in_frame && slot_idx != '0 && hit) begin
            stg_nx[rel[IDX_W-1:0]] = above[rel[IDX_W-1:0]];
            commit = last;
        end
    end

    // Slot counting, start-code check and relay commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame       <= 1'b0;
            slot_idx       <= '0;
            staged         <= '0;
            relay          <= '0;
            frame_valid    <= 1'b0;
            start_code_err <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (evt.brk_stb) begin
                in_frame       <= 1'b1;
                slot_idx       <= '0;
                start_code_err <= 1'b0;
            end else if (evt.ferr_stb) begin
                in_frame <= 1'b0;
            end else if (evt.byte_stb && in_frame) begin
                if (slot_idx != SLOT_W'(MAX_SLOTS + 1)) slot_idx <= slot_idx + 1'b1;
                if (slot_idx == '0 && evt.data != 8'h00) begin
                    start_code_err <= 1'b1;
                    in_frame       <= 1'b0;
                end
                staged <= stg_nx;
                if (commit) begin
                    relay       <= stg_nx;
                    frame_valid <= 1'b1;
                end
            end
        end
    end

    // Saturating framing-error counter
    always_ff @(posedge clk) begin
        if (!rst_n)                              ferr_count <= '0;
        else if (evt.ferr_stb && ferr_count != '1) ferr_count <= ferr_count + 1'b1;
    end

    // Refresh-window timer; stale from reset until the first accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stl_cnt <= STL_W'(STALE_CLKS);
            stale   <= 1'b1;
        end else if (frame_valid) begin
            stl_cnt <= '0;
            stale   <= 1'b0;
        end else if (stl_cnt < STL_W'(STALE_CLKS)) begin
            stl_cnt <= stl_cnt + 1'b1;
        end else begin
            stale <= 1'b1;
        end
    end

    // R7: relays change only together with the accept strobe
    p_relay_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (relay != $past(relay)) |-> frame_valid);

    // R5: a bad start code never coexists with an accepted frame
    p_bad_code_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_code_err |-> !frame_valid);

    // R8: strobe is a single cycle
    p_strobe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R9: error count never goes down
    p_count_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_count >= $past(ferr_count));

    // R10: an accepted frame clears the stale flag on the next cycle
    p_stale_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !stale);

endmodule

// File: rtl/dmx_relay_rx.sv
// DMX512 relay receiver top: line sampler, byte receiver, frame controller.
// Assumes: rx_line idles high; CLKS_PER_TICK * 16 clocks make one 4 us bit.
module dmx_relay_rx
    import dmx_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 25,
    parameter int OVS           = 16,
    parameter int N_RELAY       = 8,
    parameter int MAX_SLOTS     = 512,
    parameter int THRESH        = 127,
    parameter int CNT_W         = 8,
    parameter int STALE_CLKS    = 125_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_line,
    input  logic [$clog2(MAX_SLOTS+2)-1:0] base_chan,
    output logic [N_RELAY-1:0]             relay,
    output logic                           frame_valid,
    output logic                           start_code_err,
    output logic                           stale,
    output logic [CNT_W-1:0]               ferr_count
);
    logic    smp_en;
    logic    smp;
    rx_evt_t evt;

    dmx_line_sampler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_line (rx_line),
        .smp_en  (smp_en),
        .smp     (smp)
    );

    dmx_byte_rx #(.OVS(OVS)) u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .smp    (smp),
        .evt    (evt)
    );

    dmx_frame_ctl #(
        .N_RELAY    (N_RELAY),
        .MAX_SLOTS  (MAX_SLOTS),
        .THRESH     (THRESH),
        .CNT_W      (CNT_W),
        .STALE_CLKS (STALE_CLKS)
    ) u_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt            (evt),
        .base_chan      (base_chan),
        .relay          (relay),
        .frame_valid    (frame_valid),
        .start_code_err (start_code_err),
        .stale          (stale),
        .ferr_count     (ferr_count)
    );

endmodule

// File: tb/dmx_relay_rx_test.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of frames, then directed corner cases.
module dmx_relay_rx_test;
    localparam int TPK   = 2;
    localparam int BITC  = TPK * 16;
    localparam int STALE = 20000;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic [9:0]    base = 10'd1;
    logic [7:0]    relay;
    logic          fv, sce, stale;
    logic [CW-1:0] fec;

    int tests = 0, fails = 0, fv_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmx_relay_rx #(.CLKS_PER_TICK(TPK), .CNT_W(CW), .STALE_CLKS(STALE)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .base_chan(base),
        .relay(relay), .frame_valid(fv), .start_code_err(sce),
        .stale(stale), .ferr_count(fec)
    );

    // Count strobe cycles
    always @(posedge clk) if (rst_n && fv) fv_cnt <= fv_cnt + 1;

    // base(10) nslots(10) start code(8) seed(8) break bits(9) mab bits(4)
    typedef struct packed {
        logic [9:0] b; logic [9:0] n; logic [7:0] sc; logic [7:0] seed;
        logic [8:0] brk; logic [3:0] mab;
    } vec_t;
    localparam vec_t VEC [6] = '{
        '{10'd1, 10'd8,  8'h00, 8'd3,   9'd22,  4'd2},
        '{10'd5, 10'd14, 8'h00, 8'd11,  9'd30,  4'd3},
        '{10'd5, 10'd14, 8'h55, 8'd7,   9'd22,  4'd2},
        '{10'd9, 10'd12, 8'h00, 8'd5,   9'd22,  4'd2},
        '{10'd9, 10'd16, 8'h00, 8'd5,   9'd250, 4'd2},
        '{10'd2, 10'd9,  8'h00, 8'd200, 9'd22,  4'd8}
    };

    function automatic logic [7:0] slot_val(input int k, input int seed);
        return 8'((k * 29 + seed * 7 + k * seed) & 255);
    endfunction

    function automatic logic [7:0] map_relays(input int b, input int seed);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (slot_val(b + i, seed) > 8'd127);
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int bits);
        rx = v;
        repeat (bits * BITC) @(negedge clk);
    endtask

    // One bit; with glitch, a two-clock inverted pulse near the bit centre
    task automatic send_bit(input logic v, input bit glitch);
        rx = v;
        if (!glitch) repeat (BITC) @(negedge clk);
        else begin
            repeat (BITC / 2 - 1) @(negedge clk);
            rx = ~v; repeat (2) @(negedge clk);
            rx = v;  repeat (BITC / 2 - 1) @(negedge clk);
        end
    endtask

    // Slot: start, 8 data LSB first, stop bits (stop_ok=0 gives a low stop)
    task automatic send_byte(input logic [7:0] v, input int gbit, input bit stop_ok);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i], i == gbit);
        if (stop_ok) begin send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); end
        else begin send_bit(1'b0, 1'b0); hold(1'b1, 2); end
    endtask

    task automatic send_slots(input int n, input int seed, input int gslot);
        for (int k = 1; k <= n; k++) send_byte(slot_val(k, seed), (k == gslot) ? 7 : -1, 1'b1);
        hold(1'b1, 3);
    endtask

    initial begin
        logic [7:0] exp_r;
        int f0;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11 relay", relay, 0);
        chk("R11 frame_valid", fv, 0);
        chk("R11 start_code_err", sce, 0);
        chk("R11 ferr_count", fec, 0);
        chk("R11 stale", stale, 1);
        rst_n = 1'b1;
        hold(1'b1, 3);
        exp_r = 8'h00;

        // Table walk: R2 R3 R5 R6 R7 R8
        foreach (VEC[j]) begin
            base = VEC[j].b;
            f0 = fv_cnt;
            hold(1'b0, int'(VEC[j].brk));
            hold(1'b1, int'(VEC[j].mab));
            send_byte(VEC[j].sc, -1, 1'b1);
            send_slots(int'(VEC[j].n), int'(VEC[j].seed), -1);
            if (VEC[j].sc == 8'h00 && int'(VEC[j].n) >= int'(VEC[j].b) + 7) begin
                exp_r = map_relays(int'(VEC[j].b), int'(VEC[j].seed));
                chk("R6 R3 relay map", relay, exp_r);
                chk("R8 one strobe", fv_cnt - f0, 1);
                chk("R10 stale cleared", stale, 0);
            end else begin
                chk("R7 R5 relays held", relay, exp_r);
                chk("R7 R5 no strobe", fv_cnt - f0, 0);
            end
            chk("R5 start code flag", sce, (VEC[j].sc != 8'h00) ? 1 : 0);
        end
        chk("R2 breaks not counted", fec, 0);

        // R4: half-bit blip after break, then low again, then short mark
        base = 10'd3; f0 = fv_cnt;
        hold(1'b0, 22);
        rx = 1'b1; repeat (BITC / 2) @(negedge clk);
        hold(1'b0, 3);
        hold(1'b1, 2);
        send_byte(8'h00, -1, 1'b1);
        send_slots(10, 41, -1);
        exp_r = map_relays(3, 41);
        chk("R4 relay after blip", relay, exp_r);
        chk("R4 strobe after blip", fv_cnt - f0, 1);
        chk("R4 start code ok", sce, 0);

        // R1: single-sample glitch in the MSB of each mapped slot
        base = 10'd4; f0 = fv_cnt;
        hold(1'b0, 22); hold(1'b1, 2);
        send_byte(8'h00, -1, 1'b1);
        for (int k = 1; k <= 11; k++)
            send_byte(slot_val(k, 90), (k >= 4) ? 7 : -1, 1'b1);
        hold(1'b1, 3);
        exp_r = map_relays(4, 90);
        chk("R1 glitch rejected", relay, exp_r);
        chk("R1 strobe", fv_cnt - f0, 1);

        // R9: framing error inside a frame drops it
        base = 10'd2; f0 = fv_cnt;
        hold(1'b0, 22); hold(1'b1, 2);
        send_byte(8'h00, -1, 1'b1);
        send_byte(8'h5A, -1, 1'b0);
        for (int k = 2; k <= 10; k++) send_byte(slot_val(k, 123), -1, 1'b1);
        hold(1'b1, 3);
        chk("R9 count one", fec, 1);
        chk("R9 relays held", relay, exp_r);
        chk("R9 no strobe", fv_cnt - f0, 0);
        for (int k = 0; k < 4; k++) send_byte(8'h81, -1, 1'b0);
        hold(1'b1, 2);
        chk("R9 saturated", fec, (1 << CW) - 1);

        // R10: refresh window expires, relays held, then recover
        repeat (STALE + 200) @(negedge clk);
        chk("R10 stale raised", stale, 1);
        chk("R10 relays held", relay, exp_r);
        base = 10'd1;
        hold(1'b0, 22); hold(1'b1, 2);
        send_byte(8'h00, -1, 1'b1);
        send_slots(8, 17, -1);
        chk("R10 stale cleared", stale, 0);
        chk("R10 R6 relay", relay, map_relays(1, 17));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule